// File: doc/BRIEF.md
# Conversion Result Queue with Fill-Level Flag

This block is a four-slot queue that holds converter results until software reads them. The conversion engine writes one result per cycle by pulsing `push_i`. A read of the data register pops the oldest result into `head_o`. Reading `newest_o` returns the most recently stored result and leaves the queue unchanged.

The ready flag `ready_o` is driven by a programmable fill threshold rather than by a simple not-empty test. A policy input selects what happens when a result arrives while all four slots are occupied. In one mode the new result is discarded. In the other mode the oldest stored result is replaced. In both modes, a write that finds the queue full raises a one-cycle `spill_o` pulse.

Top module: `res_fifo_wm`

## Requirements
- R1: While `rst_n` is low, and on the first sampled cycle after it rises, the outputs read as follows: `fill_o` = 0, `head_o` = 0, `newest_o` = 0, `spill_o` = 0. `ready_o` is 0 for every threshold setting.
- R2: An accepted push raises `fill_o` by one on the next cycle. A pop (`pop_i` high while `fill_o` > 0) lowers it by one. Pops return results in write order, and `head_o` updates on the cycle after `pop_i`.
- R3: A pop while `fill_o` = 0 has no effect. `head_o` keeps the last popped value and `fill_o` stays 0.
- R4: A push and a pop in the same cycle on a non-empty queue leave `fill_o` unchanged. This also holds when the queue is full, and no spill is flagged in that case.
- R5: With `clobber_i` = 0, a push into a full queue without a pop is discarded. `fill_o` stays 4, and the stored results and `newest_o` are unchanged.
- R6: With `clobber_i` = 1, a push into a full queue without a pop drops the oldest result and stores the new one as the newest. `fill_o` stays 4.
- R7: `spill_o` is high for exactly one cycle, the cycle after a push that meets a full queue with no pop. This applies in both policies. `spill_o` is low at all other times.
- R8: `ready_o` is high exactly when `fill_o` ≥ `thresh_i` + 1. The 2-bit code 0..3 selects a threshold of 1..4. `ready_o` falls when a pop takes `fill_o` below the threshold.
- R9: `newest_o` holds the last result that was actually stored, including after it has been popped. It is 0 after reset, and reading it never pops the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Write strobe from the conversion engine |
| push_data_i | input | 12 | Result written with `push_i` |
| pop_i | input | 1 | Data-register read strobe |
| clobber_i | input | 1 | Full policy: 1 overwrites the oldest result, 0 drops the new one |
| thresh_i | input | 2 | Ready threshold code (threshold = code + 1) |
| head_o | output | 12 | Last popped result |
| newest_o | output | 12 | Most recently stored result |
| fill_o | output | 3 | Number of unread results |
| ready_o | output | 1 | Fill level has reached the threshold |
| spill_o | output | 1 | One-cycle pulse on a write into a full queue |

## Verification
The bench drives the queue into the full state under both policies. A design that lets a dropped result leak into `newest_o` fails R5. A design that forgets to advance the read side on overwrite would let `fill_o` pass four or would return a stale oldest result, which fails R6. A push and a pop on a full queue must neither spill nor lose a result, and this catches designs that test fullness before applying the pop. Pops on an empty queue must leave `head_o` alone. Every threshold code is swept, so an off-by-one in the threshold decode shows up as a wrong `ready_o`.

// File: rtl/res_fifo_pkg.sv
package res_fifo_pkg;
  // Per-cycle decisions made by the pointer control
  typedef struct packed {
    logic push;     // store the incoming result
    logic pop;      // move the head into the read register
    logic clobber;  // full queue, overwrite policy: retire oldest
  } rf_op_t;
endpackage

// File: rtl/rf_ptr_ctrl.sv
module rf_ptr_ctrl
  import res_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             clobber_i,
  output rf_op_t           op_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] fill_o,
  output logic             spill_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] fill_q, fill_d;
  logic             spill_q, spill_d;
  logic             full, empty, retire;
  rf_op_t           op;

  always_comb begin
    full       = (fill_q == FULL_CNT);
    empty      = (fill_q == '0);
    op.pop     = pop_i & ~empty;
    op.clobber = push_i & full & ~op.pop & clobber_i;
    op.push    = push_i & (~full | op.pop | clobber_i);
    retire     = op.pop | op.clobber;
    spill_d    = push_i & full & ~op.pop;

    wr_ptr_d = wr_ptr_q;
    if (op.push) wr_ptr_d = (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
    rd_ptr_d = rd_ptr_q;
    if (retire) rd_ptr_d = (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;

    fill_d = fill_q;
    if (op.push && !retire) fill_d = fill_q + 1'b1;
    else if (!op.push && retire) fill_d = fill_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
      spill_q  <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      fill_q   <= fill_d;
      spill_q  <= spill_d;
    end
  end

  assign op_o     = op;
  assign wr_ptr_o = wr_ptr_q;
  assign rd_ptr_o = rd_ptr_q;
  assign fill_o   = fill_q;
  assign spill_o  = spill_q;
endmodule

// File: rtl/rf_store.sv
module rf_store
  import res_fifo_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rf_op_t            op_i,
  input  logic [PTR_W-1:0]  wr_ptr_i,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] head_o,
  output logic [DATA_W-1:0] newest_o
);
  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DATA_W-1:0] head_q, newest_q;

  // Storage slots: no reset, each with its own write enable
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = op_i.push && (wr_ptr_i == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_we) slot_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q   <= '0;
      newest_q <= '0;
    end else begin
      if (op_i.pop)  head_q   <= slot_q[rd_ptr_i];
      if (op_i.push) newest_q <= wdata_i;
    end
  end

  assign head_o   = head_q;
  assign newest_o = newest_q;
endmodule

// File: rtl/rf_watermark.sv
module rf_watermark #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int WM_W  = $clog2(DEPTH)
) (
  input  logic [CNT_W-1:0] fill_i,
  input  logic [WM_W-1:0]  thresh_i,
  output logic             ready_o
);
  logic [CNT_W-1:0] level_need;
  always_comb begin
    level_need = CNT_W'(thresh_i) + 1'b1;
    ready_o    = (fill_i >= level_need);
  end
endmodule

// File: rtl/res_fifo_wm.sv
module res_fifo_wm
  import res_fifo_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int WM_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic              clobber_i,
  input  logic [WM_W-1:0]   thresh_i,
  output logic [DATA_W-1:0] head_o,
  output logic [DATA_W-1:0] newest_o,
  output logic [CNT_W-1:0]  fill_o,
  output logic              ready_o,
  output logic              spill_o
);
  rf_op_t           op;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  rf_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .clobber_i(clobber_i), .op_o(op), .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr),
    .fill_o(fill_o), .spill_o(spill_o)
  );

  rf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .op_i(op), .wr_ptr_i(wr_ptr), .rd_ptr_i(rd_ptr),
    .wdata_i(push_data_i), .head_o(head_o), .newest_o(newest_o)
  );

  rf_watermark #(.DEPTH(DEPTH)) u_wm (
    .fill_i(fill_o), .thresh_i(thresh_i), .ready_o(ready_o)
  );
endmodule

// File: rtl/res_fifo_wm_chk.sv
module res_fifo_wm_chk #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int WM_W  = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_i,
  input logic              pop_i,
  input logic              clobber_i,
  input logic [WM_W-1:0]   thresh_i,
  input logic [DATA_W-1:0] head_o,
  input logic [DATA_W-1:0] newest_o,
  input logic [CNT_W-1:0]  fill_o,
  input logic              ready_o,
  input logic              spill_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_o <= FULL_CNT); // R2

  AST_EMPTY_POP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_o == '0 && pop_i && !push_i) |=> ($stable(head_o) && fill_o == '0)); // R3

  AST_PUSH_POP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_o != '0 && push_i && pop_i) |=> ($stable(fill_o) && !spill_o)); // R4

  AST_DROP_KEEPS_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_o == FULL_CNT && push_i && !pop_i && !clobber_i) |=> ($stable(newest_o) && fill_o == FULL_CNT)); // R5

  AST_CLOBBER_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_o == FULL_CNT && push_i && !pop_i && clobber_i) |=> (fill_o == FULL_CNT)); // R6

  AST_SPILL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    spill_o |-> ($past(fill_o) == FULL_CNT && $past(push_i) && !$past(pop_i))); // R7

  AST_READY_FALLS_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ready_o) && $stable(thresh_i)) |-> $past(pop_i)); // R8
endmodule

bind res_fifo_wm res_fifo_wm_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .clobber_i(clobber_i),
  .thresh_i(thresh_i), .head_o(head_o), .newest_o(newest_o), .fill_o(fill_o),
  .ready_o(ready_o), .spill_o(spill_o)
);

// File: tb/res_fifo_wm_bench.sv
module res_fifo_wm_bench;
  localparam int CLK_P = 10;
  localparam int DW    = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          push_i, pop_i, clobber_i;
  logic [DW-1:0] push_data_i;
  logic [1:0]    thresh_i;
  logic [DW-1:0] head_o, newest_o;
  logic [2:0]    fill_o;
  logic          ready_o, spill_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  int q[$];
  int m_head, m_newest;
  bit m_spill;

  always #(CLK_P/2) clk = ~clk;

  res_fifo_wm u_res_fifo_wm (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
    .pop_i(pop_i), .clobber_i(clobber_i), .thresh_i(thresh_i),
    .head_o(head_o), .newest_o(newest_o), .fill_o(fill_o),
    .ready_o(ready_o), .spill_o(spill_o)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_ready(int lvl, int code);
    return lvl >= code + 1;
  endfunction

  // Reference step for one clock with the currently applied inputs
  task automatic model_step();
    bit did_pop;
    did_pop = pop_i && q.size() > 0;
    m_spill = 0;
    if (did_pop) m_head = q.pop_front();
    if (push_i) begin
      if (did_pop || q.size() < 4) begin
        q.push_back(int'(push_data_i)); m_newest = int'(push_data_i);
      end else begin
        m_spill = 1;
        if (clobber_i) begin
          void'(q.pop_front()); q.push_back(int'(push_data_i));
          m_newest = int'(push_data_i);
        end
      end
    end
  endtask

  task automatic compare(string ctx);
    check({ctx, " R2 fill"},   int'(fill_o),   q.size());
    check({ctx, " R2 head"},   int'(head_o),   m_head);
    check({ctx, " R9 newest"}, int'(newest_o), m_newest);
    check({ctx, " R8 ready"},  int'(ready_o),  int'(exp_ready(q.size(), int'(thresh_i))));
    check({ctx, " R7 spill"},  int'(spill_o),  int'(m_spill));
  endtask

  // Apply inputs at negedge, run one clock, compare at next negedge
  task automatic cyc(bit w, int d, bit r, bit ow, int th, string ctx);
    push_i = w; push_data_i = DW'(d); pop_i = r; clobber_i = ow; thresh_i = 2'(th);
    @(posedge clk);
    @(negedge clk);
    model_step();
    compare(ctx);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; push_i = 0; pop_i = 0; clobber_i = 0; push_data_i = '0; thresh_i = 0;
    q.delete(); m_head = 0; m_newest = 0; m_spill = 0;
    repeat (3) @(negedge clk);
    // R1: reset values, ready low for each code
    for (int t = 0; t < 4; t++) begin
      thresh_i = 2'(t); #1;
      check("R1 ready in reset", int'(ready_o), 0);
    end
    check("R1 fill", int'(fill_o), 0);
    check("R1 head", int'(head_o), 0);
    check("R1 newest", int'(newest_o), 0);
    check("R1 spill", int'(spill_o), 0);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, "R1 after release");

    // R3: pop on empty
    cyc(0, 0, 1, 0, 0, "R3 empty pop");
    // fill to four with threshold 4 (code 3)
    for (int i = 0; i < 4; i++) cyc(1, 16'h100 + i, 0, 0, 3, "R2 fill");
    // R5: drop policy on full
    cyc(1, 12'hABC, 0, 0, 3, "R5 drop");
    // R4: push and pop on full
    cyc(1, 12'h222, 1, 0, 3, "R4 full push pop");
    // R6: overwrite policy on full
    cyc(1, 12'h333, 0, 1, 3, "R6 clobber");
    cyc(1, 12'h344, 0, 1, 2, "R6 clobber twice");
    // drain: R8 ready falls, order checked
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, 1, "R2 drain");
    // R3: head holds after drain; R9 newest kept
    cyc(0, 0, 1, 1, 0, "R3 R9 empty");
    // push with pop on empty
    cyc(1, 12'h055, 1, 0, 0, "R4 empty push pop");
    // R4 mid-level push+pop
    cyc(1, 12'h066, 0, 0, 0, "R4 setup");
    cyc(1, 12'h077, 1, 0, 1, "R4 mid");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 100) < 55, int'($urandom % 4096), ($urandom % 100) < 40,
          ($urandom % 2) == 1, int'($urandom % 4), "rand");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule